// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction on every rising clock edge. It handles nine instructions: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an unconditional jump. Instruction and data storage are separate word arrays inside the block. Both are filled through a load port while reset is held, so the core starts from a known program and data image.

Decoding happens in two levels. A main decoder turns the opcode into datapath steering bits and a 2-bit operation class. A second decoder combines that class with the function field to pick one of the ALU's 4-bit operation codes. The next PC is chosen from three values: the sequential address, a PC-relative branch target and a region-absolute jump target. A combinational debug read port shows any register, and the current PC is visible on an output.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and every register reads 0 on the debug port.
- R2: Register 0 always reads zero, and an instruction that names register 0 as destination leaves it zero.
- R3: Opcode 0 with bits 10:6 zero is a register operation: rd (bits 15:11) receives rs (25:21) op rt (20:16). The operation is picked by funct (bits 5:0): 32 add, 34 subtract, 36 and, 37 or, 42 signed less-than giving 1 or 0.
- R4: Opcode 35 loads the word at rs + sign-extended bits 15:0 into rt. Address bits 1:0 are ignored, and the word index is the low address bits above them, modulo the memory depth.
- R5: Opcode 43 writes rt to the data word addressed as in R4 and changes no register.
- R6: Opcode 4 compares rs and rt. If they are equal the PC becomes PC+4 plus the sign-extended immediate shifted left by two. Otherwise it becomes PC+4.
- R7: Opcode 2 sets the PC to bits 31:28 of PC+4, then bits 25:0 of the instruction, then two zero bits.
- R8: Every instruction other than a taken branch or a jump advances the PC by 4.
- R9: Any other opcode is a no-op that writes nothing. So is an opcode-0 word whose funct is not one of the five in R3 or whose bits 10:6 are nonzero.
- R10: pc_o is always a multiple of 4.
- R11: dbg_rdata_o shows, in the same cycle, the register selected by dbg_raddr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also blocks store writes |
| ld_we_i | input | 1 | Load-port write strobe |
| ld_dmem_i | input | 1 | Load-port target: 1 data array, 0 instruction array |
| ld_addr_i | input | MEM_AW | Load-port word index |
| ld_wdata_i | input | 32 | Load-port write word |
| dbg_raddr_i | input | 5 | Debug register index |
| dbg_rdata_o | output | 32 | Debug register value |
| pc_o | output | 32 | Current program counter |

## Verification
The hardest situations to reach from the ports are the ones that depend on data-dependent control flow. Examples are a branch taken because two loaded values happen to match, a store followed later by a load from the same aliased word, and a jump landing inside a region that is then executed again. The bench reaches these by running long random programs in lockstep against its own instruction-level model. Register indices are narrowed to eight so that equal operands and aliasing happen often. A directed program first forces each opcode, a write to register 0, an address with nonzero low bits and each no-op form.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_J     = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_code_e;

  typedef struct packed {
    logic      dst_rd;
    logic      b_imm;
    logic      wb_mem;
    logic      reg_we;
    logic      mem_re;
    logic      mem_we;
    logic      branch;
    logic      jump;
    op_class_e op_class;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
`timescale 1ns/1ps
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.op_class = CLS_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd   = 1'b1;
        ctrl_o.reg_we   = 1'b1;
        ctrl_o.op_class = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_re = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.reg_we = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch   = 1'b1;
        ctrl_o.op_class = CLS_SUB;
      end
      OP_J: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
`timescale 1ns/1ps
module sc_alu_dec
  import sc_pkg::*;
(
  input  op_class_e  op_class_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] shamt_i,
  output alu_code_e  alu_code_o,
  output logic       fn_ok_o
);
  always_comb begin
    alu_code_o = ALU_ADD;
    fn_ok_o    = 1'b1;
    case (op_class_i)
      CLS_ADD: alu_code_o = ALU_ADD;
      CLS_SUB: alu_code_o = ALU_SUB;
      CLS_FUNCT: begin
        fn_ok_o = (shamt_i == 5'd0);
        case (funct_i)
          FN_ADD:  alu_code_o = ALU_ADD;
          FN_SUB:  alu_code_o = ALU_SUB;
          FN_AND:  alu_code_o = ALU_AND;
          FN_OR:   alu_code_o = ALU_OR;
          FN_SLT:  alu_code_o = ALU_SLT;
          default: begin
            alu_code_o = ALU_AND;
            fn_ok_o    = 1'b0;
          end
        endcase
      end
      default: fn_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_code_e       code_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    case (code_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_NOR: y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int RF_AW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RF_AW-1:0] ra_a_i,
  input  logic [RF_AW-1:0] ra_b_i,
  input  logic [RF_AW-1:0] ra_d_i,
  output logic [XLEN-1:0]  rd_a_o,
  output logic [XLEN-1:0]  rd_b_o,
  output logic [XLEN-1:0]  rd_d_o,
  input  logic             we_i,
  input  logic [RF_AW-1:0] wa_i,
  input  logic [XLEN-1:0]  wd_i
);
  localparam int NREGS = 1 << RF_AW;
  localparam int NRD   = 3;

  logic [XLEN-1:0]  regs [NREGS];
  logic [RF_AW-1:0] ra   [NRD];
  logic [XLEN-1:0]  rd   [NRD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign ra[0] = ra_a_i;
  assign ra[1] = ra_b_i;
  assign ra[2] = ra_d_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end

  assign rd_a_o = rd[0];
  assign rd_b_o = rd[1];
  assign rd_d_o = rd[2];
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic              ld_dmem_i,
  input  logic [MEM_AW-1:0] ld_addr_i,
  input  logic [31:0]       ld_wdata_i,
  input  logic [4:0]        dbg_raddr_i,
  output logic [31:0]       dbg_rdata_o,
  output logic [31:0]       pc_o
);
  localparam int MEM_WORDS = 1 << MEM_AW;

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];

  logic [31:0] pc_q, pc_next, pc_plus4, br_target, j_target;
  logic [31:0] instr, sext, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt, wa;
  logic [MEM_AW-1:0] dm_idx;
  logic        alu_zero, fn_ok, rf_we, dm_we, take_br;
  ctrl_t       ctrl;
  alu_code_e   alu_code;

  // instruction array: load port only
  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem[ld_addr_i] <= ld_wdata_i;
  end

  assign instr  = imem[pc_q[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign sext   = {{16{instr[15]}}, instr[15:0]};

  sc_main_dec u_mdec (
    .op_i   (opcode),
    .ctrl_o (ctrl)
  );

  sc_alu_dec u_adec (
    .op_class_i (ctrl.op_class),
    .funct_i    (funct),
    .shamt_i    (shamt),
    .alu_code_o (alu_code),
    .fn_ok_o    (fn_ok)
  );

  assign rf_we   = ctrl.reg_we & fn_ok;
  assign wa      = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

  sc_regfile #(.XLEN(32), .RF_AW(5)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (rs),
    .ra_b_i (rt),
    .ra_d_i (dbg_raddr_i),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .rd_d_o (dbg_rdata_o),
    .we_i   (rf_we),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.b_imm ? sext : rt_val;

  sc_alu #(.XLEN(32)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .code_i (alu_code),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // data array: load port has priority, stores blocked in reset
  assign dm_idx   = alu_y[MEM_AW+1:2];
  assign dm_we    = ctrl.mem_we & rst_ni;
  assign dm_rdata = ctrl.mem_re ? dmem[dm_idx] : '0;

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i) dmem[ld_addr_i] <= ld_wdata_i;
    else if (dm_we)           dmem[dm_idx]    <= rt_val;
  end

  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + (sext << 2);
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br   = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)    pc_next = j_target;
    else if (take_br) pc_next = br_target;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc,
  input logic [5:0]  op,
  input logic [25:0] jfield,
  input logic        rf_we,
  input logic        dm_we,
  input logic        br,
  input logic        jmp,
  input logic        zero,
  input logic [4:0]  dbg_a,
  input logic [31:0] dbg_d
);
  logic [31:0] pc4_c, boff_c;
  logic        op_known;
  assign pc4_c    = pc + 32'd4;
  assign boff_c   = {{14{jfield[15]}}, jfield[15:0], 2'b00};
  assign op_known = (op == 6'd0) || (op == 6'd35) || (op == 6'd43) ||
                    (op == 6'd4) || (op == 6'd2);

  // R10
  pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc[1:0] == 2'b00);

  // R2
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_a == 5'd0 |-> dbg_d == 32'd0);

  // R7
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp |=> pc == {$past(pc4_c[31:28]), $past(jfield), 2'b00});

  // R6
  branch_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br && !zero |=> pc == $past(pc4_c));

  // R6
  branch_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br && zero |=> pc == $past(pc4_c) + $past(boff_c));

  // R9
  unknown_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> !rf_we && !dm_we);

  // R5
  store_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we |-> !rf_we);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pc     (pc_q),
  .op     (opcode),
  .jfield (instr[25:0]),
  .rf_we  (rf_we),
  .dm_we  (dm_we),
  .br     (ctrl.branch),
  .jmp    (ctrl.jump),
  .zero   (alu_zero),
  .dbg_a  (dbg_raddr_i),
  .dbg_d  (dbg_rdata_o)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_we_i = 1'b0, ld_dmem_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [31:0]   ld_wdata_i = '0;
  logic [4:0]    dbg_raddr_i = '0;
  logic [31:0]   dbg_rdata_o, pc_o;

  always #10 clk_i = ~clk_i;

  sc_core #(.MEM_AW(AW)) uut (
    .clk_i, .rst_ni, .ld_we_i, .ld_dmem_i, .ld_addr_i, .ld_wdata_i,
    .dbg_raddr_i, .dbg_rdata_o, .pc_o
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_imem [WORDS];
  logic [31:0] m_dmem [WORDS];
  logic [31:0] m_rf   [32];
  logic [31:0] m_pc;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(input int op, rs, rt, imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input int tgt);
    return {6'd2, 26'(tgt)};
  endfunction
  function automatic bit fn_known(input logic [5:0] fn);
    return fn == 6'd32 || fn == 6'd34 || fn == 6'd36 || fn == 6'd37 || fn == 6'd42;
  endfunction
  function automatic bit op_known(input logic [5:0] op);
    return op == 6'd0 || op == 6'd35 || op == 6'd43 || op == 6'd4 || op == 6'd2;
  endfunction

  // instruction-level reference model
  task automatic exec(input logic [31:0] ins, output string ptag,
                      output string rtag, output logic [4:0] cr);
    logic [5:0]  op = ins[31:26];
    logic [4:0]  rs = ins[25:21], rt = ins[20:16], rd = ins[15:11];
    logic [31:0] a = m_rf[rs], b = m_rf[rt];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] pc4 = m_pc + 32'd4, nxt, wv, addr;
    bit wen = 0;
    nxt = pc4; ptag = "R8"; rtag = "R9"; cr = rt; wv = '0;
    case (op)
      6'd0: begin
        cr = rd;
        if (ins[10:6] == 5'd0 && fn_known(ins[5:0])) begin
          wen = 1; rtag = (rd == 0) ? "R2" : "R3";
          case (ins[5:0])
            6'd32: wv = a + b;
            6'd34: wv = a - b;
            6'd36: wv = a & b;
            6'd37: wv = a | b;
            default: wv = {31'd0, $signed(a) < $signed(b)};
          endcase
        end else ptag = "R9";
      end
      6'd35: begin
        addr = a + sx; wv = m_dmem[addr[AW+1:2]]; wen = 1;
        rtag = (rt == 0) ? "R2" : "R4";
      end
      6'd43: begin
        addr = a + sx; m_dmem[addr[AW+1:2]] = b; rtag = "R5";
      end
      6'd4: begin
        if (a == b) nxt = pc4 + (sx << 2);
        ptag = "R6"; rtag = "R6";
      end
      6'd2: begin
        nxt = {pc4[31:28], ins[25:0], 2'b00}; ptag = "R7"; rtag = "R7";
      end
      default: begin ptag = "R9"; rtag = "R9"; end
    endcase
    if (wen && cr != 0) m_rf[cr] = wv;
    m_pc = nxt;
  endtask

  function automatic logic [31:0] rand_instr();
    int k = $urandom % 100;
    int rs = $urandom % 8, rt = $urandom % 8, rd = $urandom % 8;
    int fns[5] = '{32, 34, 36, 37, 42};
    logic [5:0] op, fn;
    if (k < 40) return enc_r(rs, rt, rd, 0, fns[$urandom % 5]);
    if (k < 55) return enc_i(35, rs, rt, $urandom);
    if (k < 65) return enc_i(43, rs, rt, $urandom);
    if (k < 80) return enc_i(4, rs, rt, int'($urandom % 13) - 6);
    if (k < 85) return enc_j($urandom % (WORDS * 2));
    if (k < 92) begin
      op = 6'($urandom);
      if (op_known(op)) op = 6'h3f;
      return {op, 26'($urandom)};
    end
    fn = 6'($urandom);
    if (fn_known(fn)) fn = 6'd0;
    return enc_r(rs, rt, rd, $urandom % 2 == 0 ? 0 : $urandom % 32, fn);
  endfunction

  task automatic sweep(input string tag);
    for (int r = 0; r < 32; r++) begin
      dbg_raddr_i = 5'(r);
      #0.2;
      check(tag, $sformatf("reg %0d", r), dbg_rdata_o, m_rf[r]);
    end
  endtask

  task automatic reset_and_load();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int r = 0; r < 32; r++) m_rf[r] = '0;
    m_pc = '0;
    #0.2;
    check("R1", "pc in reset", pc_o, 32'd0);
    sweep("R1");
    for (int i = 0; i < 2 * WORDS; i++) begin
      @(negedge clk_i);
      ld_we_i    = 1'b1;
      ld_dmem_i  = (i >= WORDS);
      ld_addr_i  = AW'(i % WORDS);
      ld_wdata_i = (i >= WORDS) ? m_dmem[i % WORDS] : m_imem[i];
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;
    check("R1", "pc held in reset", pc_o, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int steps);
    for (int s = 0; s < steps; s++) begin
      string ptag, rtag;
      logic [4:0] cr;
      exec(m_imem[m_pc[AW+1:2]], ptag, rtag, cr);
      dbg_raddr_i = cr;
      @(negedge clk_i);
      check(ptag, "pc", pc_o, m_pc);
      check(rtag, $sformatf("reg %0d", cr), dbg_rdata_o, m_rf[cr]);
      check("R10", "pc alignment", {30'd0, pc_o[1:0]}, 32'd0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed program
    for (int i = 0; i < WORDS; i++) begin
      m_imem[i] = enc_i(4, 0, 0, -1);
      m_dmem[i] = 32'(i * 3 + 1);
    end
    m_dmem[0] = 32'd5;
    m_dmem[1] = 32'hFFFF_FFF0;
    m_imem[0]  = enc_i(35, 0, 1, 0);
    m_imem[1]  = enc_i(35, 0, 2, 4);
    m_imem[2]  = enc_r(1, 2, 3, 0, 32);
    m_imem[3]  = enc_r(1, 2, 4, 0, 34);
    m_imem[4]  = enc_r(1, 2, 5, 0, 36);
    m_imem[5]  = enc_r(1, 2, 6, 0, 37);
    m_imem[6]  = enc_r(2, 1, 7, 0, 42);  // R3 signed: -16 < 5
    m_imem[7]  = enc_r(1, 2, 8, 0, 42);
    m_imem[8]  = enc_r(1, 1, 0, 0, 32);  // R2 write to r0
    m_imem[9]  = enc_i(43, 0, 3, 8);     // R5
    m_imem[10] = enc_i(35, 0, 9, 8);
    m_imem[11] = enc_i(4, 1, 1, 1);      // R6 taken
    m_imem[12] = enc_r(1, 1, 10, 0, 32);
    m_imem[13] = enc_i(4, 1, 2, 5);      // R6 not taken
    m_imem[14] = enc_j(17);              // R7
    m_imem[15] = enc_r(1, 1, 11, 0, 32);
    m_imem[16] = enc_r(1, 1, 11, 0, 32);
    m_imem[17] = {6'h3f, 5'd0, 5'd1, 16'h1234};  // R9 unknown opcode
    m_imem[18] = enc_r(1, 1, 1, 0, 1);           // R9 unknown funct
    m_imem[19] = enc_r(1, 1, 1, 3, 32);          // R9 nonzero shamt
    m_imem[20] = enc_i(35, 0, 12, 3);            // R4 low bits ignored
    m_imem[21] = enc_i(43, 1, 4, -1);            // R4/R5 negative offset
    m_imem[22] = enc_i(35, 0, 13, 4);
    m_imem[23] = enc_j(40);
    reset_and_load();
    run(40);
    #0.2;
    sweep("R11");

    // random programs
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < WORDS; i++) begin
        m_imem[i] = rand_instr();
        m_dmem[i] = $urandom;
      end
      reset_and_load();
      run(1500);
      #0.2;
      sweep("R11");
    end
    summary();
    $finish;
  end
endmodule